// File: doc/BRIEF.md
# Split-Path Bang-Bang CDR Loop Filter

This block is the digital loop filter that sits between a bang-bang phase detector and the two control DACs of a clock and data recovery loop. Once per bit clock it takes one ternary decision from the detector: the clock lags, the clock leads, or no data transition was seen. It handles that decision along two separate paths. The proportional path goes through a single register and reaches the proportional DAC control pins one cycle later, with no filtering and no accumulation.

The integral path first gathers decisions in groups of four and reduces each group to one ternary vote. The vote is added into a 14-bit saturating accumulator that advances once every four bit clocks. The upper 11 bits of that accumulator feed a second-order error-feedback delta-sigma modulator. The modulator noise-shapes the slow integral word down to three levels for a small integral DAC. Keeping the two paths apart keeps the fast correction short and its dither small. The loop is meant to run heavily overdamped, with a proportional step far larger than one integral step.

Top module: `bbcdr_loop_filter`

## Requirements
- R1: A decision is read from the pair (`pd_up`, `pd_dn`): up alone means +1, dn alone means -1, and neither or both means 0. Each output pair carries the same code, and no output pair ever has both bits high.
- R2: The proportional pair shows the code of the decision sampled at a clock edge directly after that edge (one register of latency), with no other processing.
- R3: Decisions are grouped in fours. The first group is made of the decisions sampled at the first four clock edges after reset release, and each following group is the next four consecutive edges.
- R4: The vote for a group is the sign of the sum of its four codes: +1 if the sum is positive, -1 if it is negative, and 0 on a zero sum (ties included).
- R5: The integral accumulator is a 14-bit two's-complement value that starts at 0. It adds the vote of a group one edge after that group's last decision. It saturates at +8191 and -8192 and never wraps.
- R6: The modulator input x is accumulator bits 13 down to 3, read as a signed value. On each update it forms v = x + 2*e1 - e2, with e1 and e2 the last two error values and both starting at 0. It clamps v to [-2048, 2047]. It emits y = +1 if v >= 512, y = -1 if v < -512, and y = 0 otherwise. It then stores the error e = v - 1024*y.
- R7: The integral pair takes the y computed from a group two edges after that group's last decision, that is at edge 4g+5 for group g counted from 0. It holds that value at every other edge.
- R8: While reset is low, and until their first update, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_up | input | 1 | Detector decision, clock lags (+1) |
| pd_dn | input | 1 | Detector decision, clock leads (-1) |
| prop_up | output | 1 | Proportional DAC step up |
| prop_dn | output | 1 | Proportional DAC step down |
| intg_up | output | 1 | Integral DAC level +1 |
| intg_dn | output | 1 | Integral DAC level -1 |

## Verification
The assertions assume only that grouping begins at reset release. They assume nothing about the decision pair, so the illegal both-high code is allowed and must behave as a zero. The stimulus supplies a decision on every clock with no gaps, so the four-edge cadence is never broken. It mixes hand-built groups (ties, single votes, both-high codes) with random decisions. It then drives long one-sided runs that push the accumulator into both saturation limits. There the modulator's output sequence would diverge at once if the accumulator wrapped.

// File: rtl/bbcdr_lf_pkg.sv
package bbcdr_lf_pkg;

  // Signed ternary code: +1, 0, -1.
  typedef logic signed [1:0] tern_t;

  localparam tern_t TERN_POS  = 2'sb01;
  localparam tern_t TERN_ZERO = 2'sb00;
  localparam tern_t TERN_NEG  = 2'sb11;

  // Pin pair to code; the both-high pair counts as no transition.
  function automatic tern_t tern_from_pins(input logic up, input logic dn);
    if (up && !dn)      return TERN_POS;
    else if (dn && !up) return TERN_NEG;
    else                return TERN_ZERO;
  endfunction

  function automatic logic tern_is_pos(input tern_t t);
    return (t == TERN_POS);
  endfunction

  function automatic logic tern_is_neg(input tern_t t);
    return (t == TERN_NEG);
  endfunction

endpackage

// File: rtl/bbcdr_lf_prop.sv
module bbcdr_lf_prop
  import bbcdr_lf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  tern_t dec,
  output logic  step_up,
  output logic  step_dn
);

  // One register only: the fast path keeps its latency at a single cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_up <= 1'b0;
      step_dn <= 1'b0;
    end else begin
      step_up <= tern_is_pos(dec);
      step_dn <= tern_is_neg(dec);
    end
  end

endmodule

// File: rtl/bbcdr_lf_decim.sv
module bbcdr_lf_decim
  import bbcdr_lf_pkg::*;
#(
  parameter int DECIM = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  tern_t dec,
  output logic  grp_last,
  output tern_t vote,
  output logic  vote_vld
);

  localparam int SLOT_W = (DECIM > 2) ? $clog2(DECIM) : 1;
  localparam int SUM_W  = $clog2(DECIM + 1) + 1;
  localparam int HIST_N = DECIM - 1;

  logic [SLOT_W-1:0] slot_q;
  tern_t             hist_q [HIST_N];
  logic signed [SUM_W-1:0] grp_sum;

  function automatic logic signed [SUM_W-1:0] widen(input tern_t t);
    return {{(SUM_W-2){t[1]}}, t};
  endfunction

  function automatic tern_t sign_of(input logic signed [SUM_W-1:0] s);
    if (s > 0)      return TERN_POS;
    else if (s < 0) return TERN_NEG;
    else            return TERN_ZERO;
  endfunction

  assign grp_last = (slot_q == SLOT_W'(DECIM - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        slot_q <= '0;
    else if (grp_last) slot_q <= '0;
    else               slot_q <= slot_q + 1'b1;
  end

  // Delay line holding the earlier members of the current group.
  always_ff @(posedge clk) begin
    if (!rst_n) hist_q[0] <= TERN_ZERO;
    else        hist_q[0] <= dec;
  end

  for (genvar gi = 1; gi < HIST_N; gi++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rst_n) hist_q[gi] <= TERN_ZERO;
      else        hist_q[gi] <= hist_q[gi-1];
    end
  end

  always_comb begin
    grp_sum = widen(dec);
    for (int i = 0; i < HIST_N; i++) grp_sum = grp_sum + widen(hist_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vote     <= TERN_ZERO;
      vote_vld <= 1'b0;
    end else begin
      vote_vld <= grp_last;
      if (grp_last) vote <= sign_of(grp_sum);
    end
  end

endmodule

// File: rtl/bbcdr_lf_integ.sv
module bbcdr_lf_integ
  import bbcdr_lf_pkg::*;
#(
  parameter int ACC_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tern_t            vote,
  input  logic             vote_vld,
  output logic [ACC_W-1:0] acc,
  output logic             acc_vld
);

  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W:0]   sum_w;
  logic [ACC_W-1:0] acc_nxt;

  // One guard bit; disagreement of the top two bits marks overflow.
  function automatic logic [ACC_W-1:0] sat_narrow(input logic [ACC_W:0] s);
    if (s[ACC_W] != s[ACC_W-1]) return s[ACC_W] ? ACC_MIN : ACC_MAX;
    else                        return s[ACC_W-1:0];
  endfunction

  assign sum_w   = {acc[ACC_W-1], acc} + {{(ACC_W-1){vote[1]}}, vote};
  assign acc_nxt = sat_narrow(sum_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      acc_vld <= 1'b0;
    end else begin
      acc_vld <= vote_vld;
      if (vote_vld) acc <= acc_nxt;
    end
  end

endmodule

// File: rtl/bbcdr_lf_dsm2.sv
module bbcdr_lf_dsm2
  import bbcdr_lf_pkg::*;
#(
  parameter int IN_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [IN_W-1:0] x,
  output logic            lvl_up,
  output logic            lvl_dn
);

  localparam int V_W   = IN_W + 1;
  localparam int RAW_W = IN_W + 3;
  localparam logic signed [V_W-1:0] FULL  = V_W'(2 ** (IN_W - 1));
  localparam logic signed [V_W-1:0] HALF  = V_W'(2 ** (IN_W - 2));
  localparam logic signed [V_W-1:0] V_MAX = {1'b0, {(V_W-1){1'b1}}};
  localparam logic signed [V_W-1:0] V_MIN = {1'b1, {(V_W-1){1'b0}}};

  logic signed [V_W-1:0]   e1_q, e2_q;
  logic        [RAW_W-1:0] raw;
  logic signed [V_W-1:0]   v;
  tern_t                   y;
  logic signed [V_W-1:0]   e_nxt;

  function automatic logic signed [V_W-1:0] clamp_v(input logic [RAW_W-1:0] r);
    logic fits;
    fits = (&r[RAW_W-1:V_W-1]) | ~(|r[RAW_W-1:V_W-1]);
    if (fits)              return r[V_W-1:0];
    else if (r[RAW_W-1])   return V_MIN;
    else                   return V_MAX;
  endfunction

  function automatic tern_t quant3(input logic signed [V_W-1:0] val);
    if (val >= HALF)       return TERN_POS;
    else if (val < -HALF)  return TERN_NEG;
    else                   return TERN_ZERO;
  endfunction

  // Error feedback with (1 - z^-1)^2 shaping: x + 2*e[n-1] - e[n-2].
  assign raw = {{3{x[IN_W-1]}}, x}
             + {e1_q[V_W-1], e1_q, 1'b0}
             - {{2{e2_q[V_W-1]}}, e2_q};
  assign v   = clamp_v(raw);
  assign y   = quant3(v);

  always_comb begin
    if (tern_is_pos(y))      e_nxt = v - FULL;
    else if (tern_is_neg(y)) e_nxt = v + FULL;
    else                     e_nxt = v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e1_q   <= '0;
      e2_q   <= '0;
      lvl_up <= 1'b0;
      lvl_dn <= 1'b0;
    end else if (en) begin
      e2_q   <= e1_q;
      e1_q   <= e_nxt;
      lvl_up <= tern_is_pos(y);
      lvl_dn <= tern_is_neg(y);
    end
  end

endmodule

// File: rtl/bbcdr_loop_filter.sv
module bbcdr_loop_filter
  import bbcdr_lf_pkg::*;
#(
  parameter int ACC_W = 14,
  parameter int DSM_W = 11,
  parameter int DECIM = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_up,
  input  logic pd_dn,
  output logic prop_up,
  output logic prop_dn,
  output logic intg_up,
  output logic intg_dn
);

  localparam int ACC_MSB = ACC_W - 1;

  // Named internal events, visible to the bound checker.
  tern_t            pd_dec;
  logic             grp_last;
  tern_t            vote;
  logic             vote_vld;
  logic [ACC_W-1:0] acc;
  logic             acc_vld;
  logic [DSM_W-1:0] dsm_x;

  assign pd_dec = tern_from_pins(pd_up, pd_dn);
  assign dsm_x  = acc[ACC_MSB -: DSM_W];

  bbcdr_lf_prop u_prop (
    .clk     (clk),
    .rst_n   (rst_n),
    .dec     (pd_dec),
    .step_up (prop_up),
    .step_dn (prop_dn)
  );

  bbcdr_lf_decim #(.DECIM(DECIM)) u_decim (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec      (pd_dec),
    .grp_last (grp_last),
    .vote     (vote),
    .vote_vld (vote_vld)
  );

  bbcdr_lf_integ #(.ACC_W(ACC_W)) u_integ (
    .clk      (clk),
    .rst_n    (rst_n),
    .vote     (vote),
    .vote_vld (vote_vld),
    .acc      (acc),
    .acc_vld  (acc_vld)
  );

  bbcdr_lf_dsm2 #(.IN_W(DSM_W)) u_dsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (acc_vld),
    .x      (dsm_x),
    .lvl_up (intg_up),
    .lvl_dn (intg_dn)
  );

endmodule

// File: rtl/bbcdr_loop_filter_chk.sv
module bbcdr_loop_filter_chk #(
  parameter int ACC_W = 14,
  parameter int DECIM = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pd_up,
  input logic             pd_dn,
  input logic             prop_up,
  input logic             prop_dn,
  input logic             intg_up,
  input logic             intg_dn,
  input logic             grp_last,
  input logic             vote_vld,
  input logic [ACC_W-1:0] acc,
  input logic             acc_vld
);

  localparam int PH_W = (DECIM > 2) ? $clog2(DECIM) : 1;

  logic [PH_W-1:0]  ph_q;
  logic [ACC_W-1:0] acc_prev_q;
  logic [ACC_W:0]   acc_step;

  // Own phase count since reset release, independent of the design's slot counter.
  always_ff @(posedge clk) begin
    if (!rst_n)                          ph_q <= '0;
    else if (ph_q == PH_W'(DECIM - 1))   ph_q <= '0;
    else                                 ph_q <= ph_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_prev_q <= '0;
    else        acc_prev_q <= acc;
  end

  assign acc_step = {acc[ACC_W-1], acc} - {acc_prev_q[ACC_W-1], acc_prev_q};

  a_r1_prop_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prop_up, prop_dn}));

  a_r1_intg_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({intg_up, intg_dn}));

  a_r2_prop_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prop_up == $past(pd_up && !pd_dn)) && (prop_dn == $past(pd_dn && !pd_up)));

  a_r3_last_phase: assert property (@(posedge clk) disable iff (!rst_n)
    grp_last |-> (ph_q == PH_W'(DECIM - 1)));

  a_r3_vote_phase: assert property (@(posedge clk) disable iff (!rst_n)
    vote_vld |-> (ph_q == '0));

  a_r5_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |-> ((acc_step == '0) || (acc_step == 1) || (acc_step == '1)));

  a_r5_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vote_vld |=> $stable(acc));

  a_r7_intg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> $stable({intg_up, intg_dn}));

endmodule

bind bbcdr_loop_filter bbcdr_loop_filter_chk #(.ACC_W(ACC_W), .DECIM(DECIM)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pd_up    (pd_up),
  .pd_dn    (pd_dn),
  .prop_up  (prop_up),
  .prop_dn  (prop_dn),
  .intg_up  (intg_up),
  .intg_dn  (intg_dn),
  .grp_last (grp_last),
  .vote_vld (vote_vld),
  .acc      (acc),
  .acc_vld  (acc_vld)
);

// File: tb/bbcdr_loop_filter_bench.sv
`timescale 1ns/1ps
module bbcdr_loop_filter_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, pd_up, pd_dn;
  logic prop_up, prop_dn, intg_up, intg_dn;

  bbcdr_loop_filter u_bbcdr_loop_filter (
    .clk(clk), .rst_n(rst_n), .pd_up(pd_up), .pd_dn(pd_dn),
    .prop_up(prop_up), .prop_dn(prop_dn), .intg_up(intg_up), .intg_dn(intg_dn)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    prop_q[$];
  int    intg_q[$];
  string tag = "R8";
  bit    done = 1'b0;

  // Reference state, integer arithmetic.
  int m_acc = 0, m_e1 = 0, m_e2 = 0, m_sum = 0, n_sent = 0;

  function automatic int code_in(bit u, bit d);
    if (u == d) return 0;        // R1: none or both-high
    return u ? 1 : -1;
  endfunction

  function automatic int code_out(logic u, logic d);
    if (u && d) return 99;       // illegal on an output
    if (u) return 1;
    if (d) return -1;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Reference for one completed group: R4 vote, R5 saturation, R6 modulator.
  task automatic model_group();
    int vt, x, v, y;
    vt = (m_sum > 0) ? 1 : ((m_sum < 0) ? -1 : 0);
    m_acc = m_acc + vt;
    if (m_acc > 8191)  m_acc = 8191;
    if (m_acc < -8192) m_acc = -8192;
    x = m_acc >>> 3;
    v = x + 2 * m_e1 - m_e2;
    if (v > 2047)  v = 2047;
    if (v < -2048) v = -2048;
    y = (v >= 512) ? 1 : ((v < -512) ? -1 : 0);
    m_e2 = m_e1;
    m_e1 = v - 1024 * y;
    intg_q.push_back(y);
    m_sum = 0;
  endtask

  // Driver: called just after a falling edge; the next rising edge samples it.
  task automatic send(int c);
    bit u, d;
    u = (c == 1) || (c == 2);
    d = (c == -1) || (c == 2);
    pd_up = u;
    pd_dn = d;
    prop_q.push_back(code_in(u, d));
    m_sum += code_in(u, d);
    n_sent++;
    if (n_sent % 4 == 0) model_group();
    @(negedge clk);
  endtask

  task automatic send_group(int a, int b, int c, int d);
    send(a); send(b); send(c); send(d);
  endtask

  // Monitor: samples 1 ns after each rising edge, edge k counted from reset release.
  initial begin
    int k, cur;
    k = 0;
    cur = 0;
    wait (rst_n === 1'b1);
    forever begin
      @(posedge clk);
      #1;
      if (prop_q.size() > 0)
        check({"R1/R2 prop ", tag}, code_out(prop_up, prop_dn), prop_q.pop_front());
      if (k >= 5 && ((k - 5) % 4) == 0 && intg_q.size() > 0) cur = intg_q.pop_front();
      // R3 grouping, R7 timing; value from R4, R5 and R6
      check({"R3/R7 intg ", tag}, code_out(intg_up, intg_dn), cur);
      k++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    pd_up = 1'b1;
    pd_dn = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    // R8: reset state
    check("R8 prop_up", prop_up, 0);
    check("R8 prop_dn", prop_dn, 0);
    check("R8 intg_up", intg_up, 0);
    check("R8 intg_dn", intg_dn, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: ties, single votes, and both-high codes counted as zero (R1)
    tag = "R4";
    repeat (6) begin
      send_group(1, 1, -1, -1);
      send_group(1, 1, 1, 0);
      send_group(-1, 0, 0, 0);
      send_group(1, -1, 0, 0);
      send_group(1, 1, -1, 0);
      send_group(2, 2, 1, 0);
      send_group(-1, -1, 0, 1);
      send_group(2, 0, 0, 0);
      send_group(0, 0, 0, 0);
    end

    // R6: random decisions
    tag = "R6";
    for (int i = 0; i < 2000; i++) send(int'($urandom_range(0, 3)) - 1);

    // R5: drive into the positive limit, then across to the negative limit
    tag = "R5 positive limit";
    for (int i = 0; i < 8300; i++) send_group(1, 1, 1, 0);
    tag = "R5 negative limit";
    for (int i = 0; i < 16500; i++) send_group(-1, -1, 0, -1);

    tag = "R7 drain";
    repeat (12) send(0);
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end

endmodule